// File: doc/BRIEF.md
# Fault and Power Supervisor

This block collects the hardware fault signals of a server board and decides what they do to power and to the front-panel lights. Its inputs are the supply good signals, the DC/DC power-good signals, an active-low processor thermal-trip pin, fan tachometer pulses, and digital flags for out-of-range voltage, warning temperature and critical temperature. Each fault is graded. Some only light or blink LEDs. Others remove main power, and the thermal trip cuts processor power with no clock delay.

Every fault is held in a sticky status vector until the management processor pulses a clear. A fault-interrupt output pulses for one clock each time a new fault latches. While any fatal fault is held, main power stays off. Each strobe from the management processor moves the power LED one step through the boot phases. The host is held in reset until the management stack phase is reached.

Top module: `fault_supervisor`

## Requirements
- R1: status_o bits: 0 supply, 1 DC/DC, 2 thermal trip, 3 voltage, 4 warning temperature, 5 critical temperature, 6 at least one fan failed, 7 two or more fans failed. A bit sets about three clocks after its condition appears. It stays set until clr_i, and a condition that is still present wins over clr_i. After reset all bits are 0.
- R2: Any low supply input-good or power-ok bit sets bit 0. It drives psu_led_o and svc_led_o steadily high, and pwr_en_o stays high.
- R3: Any low DC/DC power-good bit sets bit 1 and drops pwr_en_o. pwr_led_o then shows the slow blink.
- R4: A low cpu_trip_ni drives cpu_pwr_en_o low in the same cycle, with no clock edge. It then sets bit 2, drops pwr_en_o, and blinks heat_led_o and svc_led_o.
- R5: volt_bad_i sets bit 3 and blinks psu_led_o and svc_led_o. temp_warn_i sets bit 4 and blinks heat_led_o and svc_led_o. Neither drops pwr_en_o.
- R6: temp_crit_i sets bit 5 and drops pwr_en_o.
- R7: A fan with no tach edge for FAN_TIMEOUT clocks fails. With one failed fan, bits 6 and fan_led_o are set, that fan's fan_mod_led_o bit is set, and power stays on. With two or more failed fans, bit 7 is also set and pwr_en_o drops.
- R8: pwr_en_o is low while any of status bits 1, 2, 5 or 7 is set. It returns high only after clr_i, once those causes are gone.
- R9: irq_o is high for one clock on each clock in which at least one new status bit or per-fan latch sets.
- R10: Each one-clock boot_stb_i pulse moves pwr_led_o one step: off after reset, then steady on, then fast blink, then off, then steady on. Further pulses leave it steady on.
- R11: host_rst_no stays low until the third boot strobe, whatever the time spent waiting, and then goes high.
- R12: The fast blink toggles every TICK_DIV clocks. The slow blink toggles four times less often.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psu_in_ok_i | input | N_PSU | Supply input-good, high when good |
| psu_out_ok_i | input | N_PSU | Supply power-ok, high when good |
| dcdc_good_i | input | N_DCDC | DC/DC power-good, high when good |
| cpu_trip_ni | input | 1 | Processor thermal trip, active low |
| fan_tach_i | input | N_FAN | Fan tachometer pulses |
| volt_bad_i | input | 1 | Voltage outside threshold |
| temp_warn_i | input | 1 | Temperature above warning threshold |
| temp_crit_i | input | 1 | Temperature above critical threshold |
| boot_stb_i | input | 1 | Boot phase advance strobe |
| clr_i | input | 1 | Clear fault latches |
| pwr_en_o | output | 1 | Main power enable |
| cpu_pwr_en_o | output | 1 | Processor power enable |
| host_rst_no | output | 1 | Host reset, active low |
| pwr_led_o | output | 1 | Front-panel power LED |
| svc_led_o | output | 1 | Service-needed LED |
| psu_led_o | output | 1 | Supply fault LED |
| heat_led_o | output | 1 | Overheat LED |
| fan_led_o | output | 1 | Front fan fault LED |
| fan_mod_led_o | output | N_FAN | Per-fan fault LEDs |
| status_o | output | 8 | Sticky fault status |
| irq_o | output | 1 | New-fault pulse |

## Verification
A table of vectors applies each fault source alone: one supply input-good, one power-ok, one DC/DC rail, the thermal pin and each threshold flag. It also applies voltage and warning temperature together, which tells the status bit map apart from the fatal/non-fatal grading and shows that a double fault gives one interrupt. Each vector is then removed before a clear, so the test can see that fatal faults keep power off until the clear. Fan tests stop one fan, then a second, to separate the single and multiple fan grades. LED tests count toggles over a window, which separates steady, fast and slow blink.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int ST_W     = 8;
  localparam int ST_PSU   = 0;
  localparam int ST_DCDC  = 1;
  localparam int ST_TRIP  = 2;
  localparam int ST_VOLT  = 3;
  localparam int ST_TWARN = 4;
  localparam int ST_TCRIT = 5;
  localparam int ST_FAN1  = 6;
  localparam int ST_FANN  = 7;
  localparam logic [ST_W-1:0] FATAL_MASK = 8'b1010_0110;

  typedef enum logic [2:0] {
    PH_OFF, PH_LOADER, PH_MPBOOT, PH_STACK, PH_RUN
  } phase_e;
endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fs_fan_mon.sv
module fs_fan_mon #(
  parameter int N_FAN   = 4,
  parameter int TIMEOUT = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_FAN-1:0] tach_i,
  output logic [N_FAN-1:0] stall_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [N_FAN-1:0] tach_s;

  fs_sync #(.W(N_FAN), .RST_VAL('0)) u_sync (
    .clk_i, .rst_ni, .d_i(tach_i), .q_o(tach_s)
  );

  for (genvar g = 0; g < N_FAN; g++) begin : g_fan
    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        prev_q <= tach_s[g];
        if (tach_s[g] ^ prev_q) cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end
    end

    assign stall_o[g] = (cnt_q == LIMIT);
  end
endmodule

// File: rtl/fs_blink.sv
module fs_blink #(
  parameter int TICK_DIV  = 100,
  parameter int SLOW_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_o,
  output logic slow_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]   pre_q;
  logic [SLOW_LOG2:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else if (pre_q == DIV_LAST) begin
      pre_q <= '0;
      ph_q  <= ph_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign fast_o = ph_q[0];
  assign slow_o = ph_q[SLOW_LOG2];
endmodule

// File: rtl/fs_boot_led.sv
module fs_boot_led
  import fs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic blink_i,
  output logic led_o,
  output logic host_rel_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        phase_q <= PH_OFF;
    else if (stb_i && phase_q != PH_RUN) phase_q <= phase_e'(phase_q + 3'd1);
  end

  always_comb begin
    unique case (phase_q)
      PH_LOADER: led_o = 1'b1;
      PH_MPBOOT: led_o = blink_i;
      PH_RUN:    led_o = 1'b1;
      default:   led_o = 1'b0;
    endcase
  end

  assign host_rel_o = (phase_q == PH_STACK) || (phase_q == PH_RUN);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter int N_PSU       = 2,
  parameter int N_DCDC      = 4,
  parameter int N_FAN       = 4,
  parameter int FAN_TIMEOUT = 100_000_000,
  parameter int TICK_DIV    = 100_000_000,
  parameter int SLOW_LOG2   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PSU-1:0]  psu_in_ok_i,
  input  logic [N_PSU-1:0]  psu_out_ok_i,
  input  logic [N_DCDC-1:0] dcdc_good_i,
  input  logic              cpu_trip_ni,
  input  logic [N_FAN-1:0]  fan_tach_i,
  input  logic              volt_bad_i,
  input  logic              temp_warn_i,
  input  logic              temp_crit_i,
  input  logic              boot_stb_i,
  input  logic              clr_i,
  output logic              pwr_en_o,
  output logic              cpu_pwr_en_o,
  output logic              host_rst_no,
  output logic              pwr_led_o,
  output logic              svc_led_o,
  output logic              psu_led_o,
  output logic              heat_led_o,
  output logic              fan_led_o,
  output logic [N_FAN-1:0]  fan_mod_led_o,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  localparam int LV     = 2 * N_PSU + N_DCDC + 4;
  localparam int IX_DC  = 2 * N_PSU;
  localparam int IX_TR  = 2 * N_PSU + N_DCDC;
  localparam logic [LV-1:0] LV_RST = {3'b000, {(LV - 3){1'b1}}};

  logic [LV-1:0]    lv_s;
  logic [N_FAN-1:0] stall;
  logic [5:0]       cond;
  logic [ST_W-1:0]  lat_q, lat_d;
  logic [N_FAN-1:0] fan_q, fan_d;
  logic             irq_q;
  logic             fast, slow, boot_led, host_rel;
  logic             hot_blink;

  fs_sync #(.W(LV), .RST_VAL(LV_RST)) u_lvl (
    .clk_i, .rst_ni,
    .d_i({temp_crit_i, temp_warn_i, volt_bad_i, cpu_trip_ni,
          dcdc_good_i, psu_out_ok_i, psu_in_ok_i}),
    .q_o(lv_s)
  );

  fs_fan_mon #(.N_FAN(N_FAN), .TIMEOUT(FAN_TIMEOUT)) u_fan (
    .clk_i, .rst_ni, .tach_i(fan_tach_i), .stall_o(stall)
  );

  fs_blink #(.TICK_DIV(TICK_DIV), .SLOW_LOG2(SLOW_LOG2)) u_blink (
    .clk_i, .rst_ni, .fast_o(fast), .slow_o(slow)
  );

  fs_boot_led u_boot (
    .clk_i, .rst_ni, .stb_i(boot_stb_i), .blink_i(fast),
    .led_o(boot_led), .host_rel_o(host_rel)
  );

  always_comb begin
    cond           = '0;
    cond[ST_PSU]   = ~&lv_s[IX_DC-1:0];
    cond[ST_DCDC]  = ~&lv_s[IX_TR-1:IX_DC];
    cond[ST_TRIP]  = ~lv_s[IX_TR];
    cond[ST_VOLT]  = lv_s[IX_TR+1];
    cond[ST_TWARN] = lv_s[IX_TR+2];
    cond[ST_TCRIT] = lv_s[IX_TR+3];
  end

  // set wins over clear
  always_comb begin
    fan_d          = (fan_q & {N_FAN{~clr_i}}) | stall;
    lat_d          = (lat_q & {ST_W{~clr_i}}) | {2'b00, cond};
    lat_d[ST_FAN1] = |fan_d;
    lat_d[ST_FANN] = ($countones(fan_d) > 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      fan_q <= '0;
      irq_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      fan_q <= fan_d;
      irq_q <= (|(lat_d & ~lat_q)) | (|(fan_d & ~fan_q));
    end
  end

  assign hot_blink     = lat_q[ST_TRIP] | lat_q[ST_TWARN] | lat_q[ST_TCRIT];
  assign pwr_en_o      = ~|(lat_q & FATAL_MASK);
  assign cpu_pwr_en_o  = pwr_en_o & cpu_trip_ni;
  assign host_rst_no   = host_rel;
  assign pwr_led_o     = lat_q[ST_DCDC] ? slow : boot_led;
  assign svc_led_o     = (hot_blink | lat_q[ST_VOLT]) ? fast
                         : (lat_q[ST_PSU] | lat_q[ST_DCDC] | lat_q[ST_FAN1]);
  assign psu_led_o     = lat_q[ST_VOLT] ? fast : lat_q[ST_PSU];
  assign heat_led_o    = hot_blink & fast;
  assign fan_led_o     = lat_q[ST_FAN1];
  assign fan_mod_led_o = fan_q;
  assign status_o      = lat_q;
  assign irq_o         = irq_q;
endmodule

// File: rtl/fs_chk.sv
module fs_chk
  import fs_pkg::*;
#(
  parameter int N_FAN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_trip_ni,
  input logic             boot_stb_i,
  input logic             clr_i,
  input logic             pwr_en_o,
  input logic             cpu_pwr_en_o,
  input logic             host_rst_no,
  input logic [N_FAN-1:0] fan_mod_led_o,
  input logic [ST_W-1:0]  status_o,
  input logic             irq_o
);
  // R8
  fatal_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & FATAL_MASK) != '0) |-> !pwr_en_o);

  // R4
  trip_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_trip_ni |-> !cpu_pwr_en_o);

  // R1
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> (($past(status_o) & ~status_o) == '0));

  // R9
  irq_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (((status_o & ~$past(status_o)) != '0) ||
               ((fan_mod_led_o & ~$past(fan_mod_led_o)) != '0)));

  // R11
  host_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(boot_stb_i) |-> !$rose(host_rst_no));
endmodule

bind fault_supervisor fs_chk #(.N_FAN(N_FAN)) u_chk (.*);

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int N_PSU = 2, N_DCDC = 4, N_FAN = 4;
  localparam int FAN_TO = 40, TDIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_PSU-1:0] vin = '1, pok = '1;
  logic [N_DCDC-1:0] pg = '1;
  logic trip_n = 1'b1, volt = 1'b0, tw = 1'b0, tc = 1'b0, stb = 1'b0, clr = 1'b0;
  logic [N_FAN-1:0] tach = '0, fan_run = '1;
  logic pwr_en, cpu_pwr, host_rst_n, pwr_led, svc_led, psu_led, heat_led, fan_led, irq;
  logic [N_FAN-1:0] fan_mod;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.N_PSU(N_PSU), .N_DCDC(N_DCDC), .N_FAN(N_FAN),
    .FAN_TIMEOUT(FAN_TO), .TICK_DIV(TDIV), .SLOW_LOG2(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .psu_in_ok_i(vin), .psu_out_ok_i(pok),
    .dcdc_good_i(pg), .cpu_trip_ni(trip_n), .fan_tach_i(tach),
    .volt_bad_i(volt), .temp_warn_i(tw), .temp_crit_i(tc),
    .boot_stb_i(stb), .clr_i(clr), .pwr_en_o(pwr_en), .cpu_pwr_en_o(cpu_pwr),
    .host_rst_no(host_rst_n), .pwr_led_o(pwr_led), .svc_led_o(svc_led),
    .psu_led_o(psu_led), .heat_led_o(heat_led), .fan_led_o(fan_led),
    .fan_mod_led_o(fan_mod), .status_o(status), .irq_o(irq));

  initial forever begin
    #20;
    for (int i = 0; i < N_FAN; i++) if (fan_run[i]) tach[i] = ~tach[i];
  end

  always @(negedge clk) if (irq) irq_cnt++;

  typedef struct packed {
    logic [1:0] vin; logic [1:0] pok; logic [3:0] pg;
    logic trip_n; logic volt; logic tw; logic tc;
    logic [7:0] st; logic pwr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b10, 2'b11, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1},
    '{2'b11, 2'b01, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1},
    '{2'b11, 2'b11, 4'hB, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0},
    '{2'b11, 2'b11, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0},
    '{2'b11, 2'b11, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h08, 1'b1},
    '{2'b11, 2'b11, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10, 1'b1},
    '{2'b11, 2'b11, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 1'b0},
    '{2'b11, 2'b11, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 8'h18, 1'b1}
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic led_sel(input int s);
    case (s)
      0: return pwr_led;
      1: return svc_led;
      2: return psu_led;
      default: return heat_led;
    endcase
  endfunction

  task automatic toggles(input int s, input int n, output int t);
    logic prev;
    t = 0;
    @(negedge clk);
    prev = led_sel(s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (led_sel(s) !== prev) t++;
      prev = led_sel(s);
    end
    #3.5;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; cyc(1); sig = 1'b0;
  endtask

  task automatic all_good();
    vin = '1; pok = '1; pg = '1; trip_n = 1'b1; volt = 1'b0; tw = 1'b0; tc = 1'b0;
  endtask

  task automatic clear_all();
    all_good(); cyc(6); pulse(clr); cyc(2);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t, i0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset status", status, 8'h00);
    chk("R9 reset irq", irq, 0);
    chk("R8 reset pwr_en", pwr_en, 1);
    chk("R10 reset pwr_led", pwr_led, 0);
    cyc(50);
    chk("R11 host held without strobe", host_rst_n, 0);

    // boot phases
    pulse(stb); cyc(1);
    chk("R10 loader led on", pwr_led, 1);
    chk("R11 host still held", host_rst_n, 0);
    pulse(stb); cyc(1);
    toggles(0, 32, t);
    chk_rng("R10 R12 boot fast blink", t, 6, 9);
    chk("R11 host held in boot", host_rst_n, 0);
    pulse(stb); cyc(1);
    chk("R10 stack led off", pwr_led, 0);
    chk("R11 host released", host_rst_n, 1);
    pulse(stb); cyc(1);
    toggles(0, 16, t);
    chk("R10 post led steady toggles", t, 0);
    chk("R10 post led on", pwr_led, 1);
    pulse(stb); cyc(1);
    chk("R10 extra strobe ignored", pwr_led, 1);

    // vector table
    foreach (VECS[k]) begin
      vin = VECS[k].vin; pok = VECS[k].pok; pg = VECS[k].pg;
      trip_n = VECS[k].trip_n; volt = VECS[k].volt; tw = VECS[k].tw; tc = VECS[k].tc;
      i0 = irq_cnt;
      cyc(6);
      chk($sformatf("R1 R2 R3 R4 R5 R6 vec%0d status", k), status, VECS[k].st);
      chk($sformatf("R8 vec%0d pwr_en", k), pwr_en, VECS[k].pwr);
      chk($sformatf("R9 vec%0d irq pulses", k), irq_cnt - i0, 1);
      all_good(); cyc(6);
      chk($sformatf("R1 vec%0d held after cause gone", k), status, VECS[k].st);
      chk($sformatf("R8 vec%0d power waits for clear", k), pwr_en, VECS[k].pwr);
      pulse(clr); cyc(2);
      chk($sformatf("R1 vec%0d cleared", k), status, 8'h00);
      chk($sformatf("R8 vec%0d power back", k), pwr_en, 1);
    end

    // thermal trip cuts cpu power without a clock edge
    @(posedge clk); #1;
    trip_n = 1'b0; #1;
    chk("R4 cpu power cut at once", cpu_pwr, 0);
    cyc(6);
    toggles(3, 32, t);
    chk_rng("R4 heat led blinks", t, 6, 9);
    toggles(1, 32, t);
    chk_rng("R4 svc led blinks", t, 6, 9);
    chk("R4 main power off", pwr_en, 0);
    clear_all();
    chk("R4 cpu power restored", cpu_pwr, 1);

    // supply fault LEDs steady
    vin[1] = 1'b0; cyc(6);
    toggles(1, 32, t);
    chk("R2 svc steady", t, 0);
    chk("R2 svc on", svc_led, 1);
    chk("R2 psu led on", psu_led, 1);
    chk("R2 heat led off", heat_led, 0);
    clear_all();

    // voltage blink + set wins over clear
    volt = 1'b1; cyc(6);
    toggles(2, 32, t);
    chk_rng("R5 psu led blinks", t, 6, 9);
    pulse(clr); cyc(2);
    chk("R1 set wins over clear", status, 8'h08);
    chk("R5 volt non-fatal", pwr_en, 1);
    clear_all();

    // dcdc slow blink
    pg[0] = 1'b0; cyc(6);
    toggles(0, 32, t);
    chk_rng("R3 R12 standby slow blink", t, 1, 3);
    clear_all();
    chk("R3 led back to steady after clear", pwr_led, 1);

    // fans
    fan_run[1] = 1'b0; cyc(20);
    chk("R7 no fail before timeout", status, 8'h00);
    cyc(50);
    chk("R7 single fan status", status, 8'h40);
    chk("R7 fan module led", fan_mod, 4'b0010);
    chk("R7 front fan led", fan_led, 1);
    chk("R7 single fan non-fatal", pwr_en, 1);
    fan_run[3] = 1'b0; cyc(60);
    chk("R7 multi fan status", status, 8'hC0);
    chk("R7 multi fan modules", fan_mod, 4'b1010);
    chk("R7 R8 multi fan fatal", pwr_en, 0);
    fan_run = '1; cyc(10);
    pulse(clr); cyc(2);
    chk("R7 fans cleared", status, 8'h00);
    chk("R8 power after fan clear", pwr_en, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule